// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line priority interrupt controllers into a sixteen-line system and runs the processor's interrupt acknowledge. Lines 0 to 7 belong to the primary bank and lines 8 to 15 to the secondary bank. The secondary bank's output is the primary bank's input 2, so that input never takes an external request. Each bank keeps its own request bits, in-service bits, a pending flag, the index it has picked, and a vector base. A shared mask input holds one blocking bit per line.

When a bank is not pending, it picks its winner on every clock edge. The primary bank's processor interrupt output follows its pending flag. A one-cycle acknowledge pulse returns an 8-bit vector in the same cycle. The vector is the primary base plus the primary index, or the secondary base plus the secondary index when the primary index is the cascade input. At the clock edge that ends the pulse, the in-service and request bits of the banks involved are updated. Both banks pick again on the following edge. The secondary bank picks first, and its new winner is visible to the primary bank's pick in the same cycle. An end-of-interrupt strobe clears one named in-service bit. An init strobe on a bank clears that bank's state and loads its vector base.

Top module: `cascade_ack_seq`

## Requirements
- R1: After synchronous reset, `intr_o` is 0, `isr_o` and `irr_o` are 0, and the vector output reads 0x0F, which is the primary base 0x08 plus 7.
- R2: A request pulse on a line sets bit n of `irr_o` for line n. A set `mask_i` bit keeps that line from being picked. Among the unmasked requests, the lowest line number wins. When the winner is a primary line n, the vector is the primary base plus n.
- R3: A bank does not present a request of the same or lower priority (same or higher index) than its lowest-numbered in-service bit. It does present a strictly higher one. There is one exception: the primary bank may present its cascade input 2 while bit 2 is already in service, so that secondary requests can nest.
- R4: A request on line 8 to 15 raises `intr_o` after the same clock edge. Its acknowledge returns the secondary base (0x70 after reset) plus (line - 8), and sets both that line's in-service bit and primary in-service bit 2.
- R5: At the edge that ends an acknowledge taken while `intr_o` is 1, `intr_o` falls and the winner's in-service bit is set. Its request bit stays clear.
- R6: `vector_o` is valid combinationally during the acknowledge cycle. It holds that value until the next acknowledge.
- R7: An acknowledge while `intr_o` is 0 returns the primary base plus 7 and leaves `isr_o` and `irr_o` unchanged.
- R8: An init strobe on the primary bank drives `intr_o` low after the next edge, clears the primary request and in-service bits, and loads the primary base from `init_base_i` with its low 3 bits cleared.
- R9: An init strobe on the secondary bank clears its state and loads the secondary base in the same way.
- R10: An end-of-interrupt strobe with `eoi_line_i` = n clears in-service bit n. Bit 3 of `eoi_line_i` selects the secondary bank. Lower-priority requests that were held back are then picked on the edge after the clear.
- R11: An external request pulse on line 2 is ignored, because that input carries only the secondary bank's output.
- R12: When a secondary line and a primary line of lower priority than input 2 are requested at the same edge, the secondary winner reaches the primary bank in that same edge and takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | One-cycle request pulses, one bit per line |
| mask_i | input | 16 | Per-line blocking mask; bit 2 blocks the cascade input |
| ack_i | input | 1 | One-cycle processor acknowledge |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_line_i | input | 4 | Line whose in-service bit is cleared |
| init_m_i | input | 1 | Primary bank init strobe |
| init_s_i | input | 1 | Secondary bank init strobe |
| init_base_i | input | 8 | Vector base loaded by an init strobe |
| intr_o | output | 1 | Processor interrupt request |
| vector_o | output | 8 | Acknowledge vector |
| isr_o | output | 16 | In-service bits, secondary in the upper byte |
| irr_o | output | 16 | Request bits, secondary in the upper byte |

## Verification
A request pulse driven before edge k shows in `irr_o`, or raises `intr_o`, right after edge k. This holds for secondary lines as well, because the cascade pick is combinational. The vector is due within the acknowledge cycle itself, before its edge. The in-service update and the fall of `intr_o` are due one edge later. The re-pick is due on the edge after that. An end-of-interrupt clear lands at its edge, and any request it releases appears one edge later. The bench drives every input at the falling edge and samples just after a falling edge, so each check reads the state left by exactly the rising edges counted above. The vector check is made 1 ns into the acknowledge cycle.

// File: rtl/pic_cas_pkg.sv
package pic_cas_pkg;
  localparam int unsigned PIC_LINES   = 8;
  localparam int unsigned PIC_VEC_W   = 8;
  localparam int unsigned PIC_CASC    = 2;
  localparam logic [7:0]  PIC_BASE_M  = 8'h08;
  localparam logic [7:0]  PIC_BASE_S  = 8'h70;
endpackage

// File: rtl/pic_cas_resolver.sv
module pic_cas_resolver #(
  parameter int unsigned LINES     = 8,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned CASC_IDX  = 2,
  parameter bit          NEST_CASC = 1'b0
) (
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] isr,
  output logic             win,
  output logic [IDX_W-1:0] win_idx
);
  int lim;

  // lowest-numbered in-service bit sets the priority ceiling
  always_comb begin
    lim = LINES;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (isr[i]) lim = i;
    end
  end

  always_comb begin
    win     = 1'b0;
    win_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req[i] && !mask[i] &&
          ((i < lim) || (NEST_CASC && (i == lim) && (i == int'(CASC_IDX))))) begin
        win     = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_cas_bank.sv
module pic_cas_bank #(
  parameter int unsigned LINES     = 8,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned CASC_IDX  = 2,
  parameter bit          NEST_CASC = 1'b0,
  parameter logic [VEC_W-1:0] BASE_RST = '0,
  localparam int unsigned IDX_W    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] req_set,
  input  logic [LINES-1:0] mask,
  input  logic             init,
  input  logic [VEC_W-1:0] init_base,
  input  logic             ack_take,
  input  logic             eoi,
  input  logic [IDX_W-1:0] eoi_idx,
  output logic [LINES-1:0] irr,
  output logic [LINES-1:0] isr,
  output logic             pending,
  output logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] base,
  output logic             fire
);
  localparam logic [VEC_W-1:0] ALIGN = ~VEC_W'((1 << IDX_W) - 1);

  logic [LINES-1:0] irr_eff, win_bit, ack_bit, eoi_bit;
  logic             win;
  logic [IDX_W-1:0] win_idx;

  assign irr_eff = irr | req_set;

  pic_cas_resolver #(
    .LINES(LINES), .IDX_W(IDX_W), .CASC_IDX(CASC_IDX), .NEST_CASC(NEST_CASC)
  ) res_i (
    .req(irr_eff), .mask(mask), .isr(isr), .win(win), .win_idx(win_idx)
  );

  assign fire    = win && !pending && !init;
  assign win_bit = fire     ? (LINES'(1) << win_idx) : '0;
  assign ack_bit = ack_take ? (LINES'(1) << idx)     : '0;
  assign eoi_bit = eoi      ? (LINES'(1) << eoi_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr     <= '0;
      isr     <= '0;
      pending <= 1'b0;
      idx     <= '0;
      base    <= BASE_RST;
    end else if (init) begin
      irr     <= '0;
      isr     <= '0;
      pending <= 1'b0;
      base    <= init_base & ALIGN;
    end else begin
      irr <= irr_eff & ~win_bit & ~ack_bit;
      isr <= (isr & ~eoi_bit) | ack_bit;
      if (ack_take) begin
        pending <= 1'b0;
      end else if (fire) begin
        pending <= 1'b1;
        idx     <= win_idx;
      end
    end
  end
endmodule

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq
  import pic_cas_pkg::*;
#(
  parameter int unsigned LINES  = PIC_LINES,
  parameter int unsigned VEC_W  = PIC_VEC_W,
  parameter int unsigned CASC   = PIC_CASC,
  parameter logic [VEC_W-1:0] BASE_M = PIC_BASE_M,
  parameter logic [VEC_W-1:0] BASE_S = PIC_BASE_S,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned ALL   = 2 * LINES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ALL-1:0]   req_i,
  input  logic [ALL-1:0]   mask_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  input  logic [IDX_W:0]   eoi_line_i,
  input  logic             init_m_i,
  input  logic             init_s_i,
  input  logic [VEC_W-1:0] init_base_i,
  output logic             intr_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [ALL-1:0]   isr_o,
  output logic [ALL-1:0]   irr_o
);
  logic [LINES-1:0] m_req, m_irr, m_isr, s_irr, s_isr;
  logic             m_pend, s_pend, m_fire, s_fire;
  logic [IDX_W-1:0] m_idx, s_idx;
  logic [VEC_W-1:0] m_base, s_base, vec_now, vec_hold;
  logic             ack_real, ack_casc;

  // primary inputs: external lines, except the cascade slot fed by the secondary pick
  for (genvar g = 0; g < LINES; g++) begin : g_mreq
    if (g == CASC) begin : g_casc
      assign m_req[g] = s_fire;
    end else begin : g_ext
      assign m_req[g] = req_i[g];
    end
  end

  assign ack_real = ack_i && m_pend;
  assign ack_casc = ack_real && (m_idx == IDX_W'(CASC));

  pic_cas_bank #(
    .LINES(LINES), .VEC_W(VEC_W), .CASC_IDX(CASC), .NEST_CASC(1'b1), .BASE_RST(BASE_M)
  ) m_bank_i (
    .clk(clk), .rst(rst), .req_set(m_req), .mask(mask_i[LINES-1:0]),
    .init(init_m_i), .init_base(init_base_i), .ack_take(ack_real),
    .eoi(eoi_i && !eoi_line_i[IDX_W]), .eoi_idx(eoi_line_i[IDX_W-1:0]),
    .irr(m_irr), .isr(m_isr), .pending(m_pend), .idx(m_idx), .base(m_base),
    .fire(m_fire)
  );

  pic_cas_bank #(
    .LINES(LINES), .VEC_W(VEC_W), .CASC_IDX(CASC), .NEST_CASC(1'b0), .BASE_RST(BASE_S)
  ) s_bank_i (
    .clk(clk), .rst(rst), .req_set(req_i[ALL-1:LINES]), .mask(mask_i[ALL-1:LINES]),
    .init(init_s_i), .init_base(init_base_i), .ack_take(ack_casc),
    .eoi(eoi_i && eoi_line_i[IDX_W]), .eoi_idx(eoi_line_i[IDX_W-1:0]),
    .irr(s_irr), .isr(s_isr), .pending(s_pend), .idx(s_idx), .base(s_base),
    .fire(s_fire)
  );

  always_comb begin
    if (!m_pend)                     vec_now = m_base + VEC_W'(LINES - 1);
    else if (m_idx == IDX_W'(CASC))  vec_now = s_base + VEC_W'(s_idx);
    else                             vec_now = m_base + VEC_W'(m_idx);
  end

  always_ff @(posedge clk) begin
    if (rst)        vec_hold <= BASE_M + VEC_W'(LINES - 1);
    else if (ack_i) vec_hold <= vec_now;
  end

  assign vector_o = ack_i ? vec_now : vec_hold;
  assign intr_o   = m_pend;
  assign isr_o    = {s_isr, m_isr};
  assign irr_o    = {s_irr, m_irr};
endmodule

// File: rtl/cascade_ack_seq_chk.sv
module cascade_ack_seq_chk #(
  parameter int unsigned ALL   = 16,
  parameter int unsigned HALF  = 8,
  parameter int unsigned VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_i,
  input logic             eoi_i,
  input logic             init_m_i,
  input logic             init_s_i,
  input logic [ALL-1:0]   req_i,
  input logic             intr_o,
  input logic [VEC_W-1:0] vector_o,
  input logic [ALL-1:0]   isr_o
);
  AST_ACK_DROPS_INTR: assert property (@(posedge clk) disable iff (rst)
    (ack_i && intr_o) |=> !intr_o); // R5

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack_i && intr_o && !init_m_i) |=> (isr_o[HALF-1:0] != '0)); // R5

  AST_INIT_DROPS_INTR: assert property (@(posedge clk) disable iff (rst)
    init_m_i |=> !intr_o); // R8

  AST_SPURIOUS_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !intr_o && !eoi_i && !init_m_i && !init_s_i && (req_i == '0))
      |=> $stable(isr_o)); // R7

  AST_VECTOR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!ack_i && !$past(ack_i) && !$past(rst)) |-> $stable(vector_o)); // R6
endmodule

bind cascade_ack_seq cascade_ack_seq_chk #(.ALL(ALL), .HALF(LINES), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst(rst), .ack_i(ack_i), .eoi_i(eoi_i), .init_m_i(init_m_i),
  .init_s_i(init_s_i), .req_i(req_i), .intr_o(intr_o), .vector_o(vector_o),
  .isr_o(isr_o)
);

// File: tb/cascade_ack_seq_tb_top.sv
`timescale 1ns/1ps
module cascade_ack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req_i = '0, mask_i = '0;
  logic        ack_i = 1'b0, eoi_i = 1'b0, init_m_i = 1'b0, init_s_i = 1'b0;
  logic [3:0]  eoi_line_i = '0;
  logic [7:0]  init_base_i = '0;
  logic        intr_o;
  logic [7:0]  vector_o;
  logic [15:0] isr_o, irr_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_ack_seq dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .mask_i(mask_i), .ack_i(ack_i),
    .eoi_i(eoi_i), .eoi_line_i(eoi_line_i), .init_m_i(init_m_i),
    .init_s_i(init_s_i), .init_base_i(init_base_i), .intr_o(intr_o),
    .vector_o(vector_o), .isr_o(isr_o), .irr_o(irr_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse(logic [15:0] v);
    @(negedge clk) req_i = v;
    @(negedge clk) req_i = '0;
  endtask

  task automatic ack_expect(logic [7:0] exp, string tag);
    @(negedge clk) ack_i = 1'b1;
    #1 check(tag, 32'(vector_o), 32'(exp));
    @(negedge clk) ack_i = 1'b0;
    check("R5 intr low after ack", 32'(intr_o), 0);
  endtask

  task automatic eoi(logic [3:0] line);
    @(negedge clk) begin eoi_i = 1'b1; eoi_line_i = line; end
    @(negedge clk) eoi_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 intr", 32'(intr_o), 0);
    check("R1 isr", 32'(isr_o), 0);
    check("R1 irr", 32'(irr_o), 0);
    check("R1 vector", 32'(vector_o), 32'h0F);
  endtask

  task automatic t_prio();
    pulse(16'h0028);
    check("R2 intr raised", 32'(intr_o), 1);
    check("R2 loser stays requested", 32'(irr_o), 32'h0020);
    ack_expect(8'h0B, "R6 vector line 3");
    check("R5 isr set", 32'(isr_o), 32'h0008);
    check("R5 irr", 32'(irr_o), 32'h0020);
    cyc(); cyc();
    check("R3 lower priority held", 32'(intr_o), 0);
    check("R6 vector held", 32'(vector_o), 32'h0B);
    eoi(4'd3); cyc();
    check("R10 released after eoi", 32'(intr_o), 1);
    ack_expect(8'h0D, "R2 vector line 5");
    eoi(4'd5);
    check("R10 isr cleared", 32'(isr_o), 0);
  endtask

  task automatic t_mask();
    mask_i = 16'h0010;
    pulse(16'h0010); cyc();
    check("R2 masked line not raised", 32'(intr_o), 0);
    check("R2 masked line requested", 32'(irr_o), 32'h0010);
    @(negedge clk) mask_i = '0;
    cyc();
    check("R2 unmasked raised", 32'(intr_o), 1);
    ack_expect(8'h0C, "R2 vector line 4");
    eoi(4'd4);
  endtask

  task automatic t_casc_ignore();
    pulse(16'h0004); cyc();
    check("R11 intr", 32'(intr_o), 0);
    check("R11 irr", 32'(irr_o), 0);
  endtask

  task automatic t_slave();
    pulse(16'h0400);
    check("R4 intr same edge", 32'(intr_o), 1);
    ack_expect(8'h72, "R4 vector line 10");
    check("R4 isr both banks", 32'(isr_o), 32'h0404);
    eoi(4'd10); eoi(4'd2);
    check("R10 isr clear", 32'(isr_o), 0);
  endtask

  task automatic t_nest();
    pulse(16'h0040);
    ack_expect(8'h0E, "R3 vector line 6");
    pulse(16'h0002);
    check("R3 higher priority nests", 32'(intr_o), 1);
    ack_expect(8'h09, "R3 vector line 1");
    check("R3 isr nested", 32'(isr_o), 32'h0042);
    eoi(4'd1); eoi(4'd6);
    pulse(16'h1000);
    ack_expect(8'h74, "R4 vector line 12");
    pulse(16'h0200);
    check("R3 cascade nests", 32'(intr_o), 1);
    ack_expect(8'h71, "R3 vector line 9");
    check("R3 isr cascade nested", 32'(isr_o), 32'h1204);
    eoi(4'd9); eoi(4'd12); eoi(4'd2);
    check("R10 isr clear", 32'(isr_o), 0);
  endtask

  task automatic t_order();
    pulse(16'h0810);
    check("R12 intr", 32'(intr_o), 1);
    ack_expect(8'h73, "R12 cascade wins");
    check("R12 line 4 still requested", 32'(irr_o), 32'h0010);
    eoi(4'd11); eoi(4'd2); cyc();
    check("R12 line 4 follows", 32'(intr_o), 1);
    ack_expect(8'h0C, "R12 vector line 4");
    eoi(4'd4);
  endtask

  task automatic t_spurious();
    mask_i = 16'h0020;
    pulse(16'h0020); cyc();
    ack_expect(8'h0F, "R7 spurious vector");
    check("R7 isr unchanged", 32'(isr_o), 0);
    check("R7 irr unchanged", 32'(irr_o), 32'h0020);
  endtask

  task automatic t_init_m();
    pulse(16'h0002);
    check("R8 intr before init", 32'(intr_o), 1);
    @(negedge clk) begin init_m_i = 1'b1; init_base_i = 8'h23; end
    @(negedge clk) init_m_i = 1'b0;
    check("R8 intr forced low", 32'(intr_o), 0);
    check("R8 irr cleared", 32'(irr_o), 0);
    mask_i = '0;
    pulse(16'h0002);
    ack_expect(8'h21, "R8 new base");
    eoi(4'd1);
    ack_expect(8'h27, "R7 spurious new base");
  endtask

  task automatic t_init_s();
    @(negedge clk) begin init_s_i = 1'b1; init_base_i = 8'h4D; end
    @(negedge clk) init_s_i = 1'b0;
    pulse(16'h8000);
    ack_expect(8'h4F, "R9 secondary base");
    eoi(4'd15); eoi(4'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc();
    t_reset();
    t_prio();
    t_mask();
    t_casc_ignore();
    t_slave();
    t_nest();
    t_order();
    t_spurious();
    t_init_m();
    t_init_s();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule